// File: doc/BRIEF.md
# DFI Software Command Injector

This block sits between a DDR memory controller and the PHY on the four-phase DFI command interface. When the host sets the ownership bit in the control register, the block drives the DFI outputs itself. Each phase has its own set of registers for the command, the row/column address, the bank, the write data, and the captured read data. The host stages a command in a phase's registers. A write to that phase's issue register then puts the command on the bus for exactly one controller clock. Firmware uses this to run memory initialisation, mode-register loads, ZQ calibration and training reads and writes before it hands the bus back to the controller.

Command registers hold active-high bits, and the block converts them to active-low chip-select, row, column and write-enable pins at its output. When the host does not own the bus, every DFI output is the controller's value, unchanged. The register port is a flat 32-bit bus with an 8-bit address. The upper address nibble selects a region and the lower nibble selects a register within it.

Top module: `dfi_sw_inject`

## Requirements
- R1: After reset the control register reads 0, and every DFI output equals the corresponding controller input.
- R2: The control register is at address 0x00 and reads back its 4 bits. Bit 0 selects software ownership, bit 1 drives CKE, bit 2 drives ODT and bit 3 drives the memory reset_n pin.
- R3: While bit 0 of the control register is 0, every DFI command, address, bank, write-data, enable, CKE, ODT and reset_n output equals its controller-side input, and read-valid is forwarded to the controller.
- R4: While software owns the bus, CKE, ODT and reset_n follow control bits 1, 2 and 3. Each phase's address, bank and write-data outputs follow that phase's registers.
- R5: Phase p (0..3) occupies addresses with upper nibble p+1. Its lower-nibble offsets are: 0 command, 1 issue, 2 address, 3 bank, 4..7 write-data words, and 8..11 read-data words. Word 0 holds bits 31:0. Each register reads back what was written or captured, and the issue register reads 0.
- R6: The command register bits are: bit 0 chip select, bit 1 write enable, bit 2 column strobe, bit 3 row strobe, bit 4 write-data enable and bit 5 read-data enable. When a command is launched, cs_n, we_n, cas_n and ras_n are the inverses of bits 0 to 3, and the two data enables equal bits 4 and 5.
- R7: A register write of a value with bit 0 set to a phase's issue offset launches that phase's staged command in the single clock after the write edge, on that phase only. A value with bit 0 clear launches nothing.
- R8: While software owns the bus and no launch is active on a phase, that phase drives NOP: cs_n, ras_n, cas_n and we_n high, and both data enables low.
- R9: A phase armed by a launched command with bit 5 set captures the DFI read data into its read-data registers on the next read-valid of that phase, then disarms. Read-valid on an unarmed phase leaves its read-data registers unchanged.
- R10: While software owns the bus, the read-valid forwarded to the controller is held low. Read data is always forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| ctl_cs_n_i | input | 4 | Controller chip select, one bit per phase |
| ctl_ras_n_i | input | 4 | Controller row strobe per phase |
| ctl_cas_n_i | input | 4 | Controller column strobe per phase |
| ctl_we_n_i | input | 4 | Controller write enable per phase |
| ctl_addr_i | input | 56 | Controller address, 14 bits per phase |
| ctl_bank_i | input | 12 | Controller bank, 3 bits per phase |
| ctl_wrdata_en_i | input | 4 | Controller write-data enable per phase |
| ctl_wrdata_i | input | 512 | Controller write data, 128 bits per phase |
| ctl_rddata_en_i | input | 4 | Controller read-data enable per phase |
| ctl_cke_i | input | 1 | Controller CKE |
| ctl_odt_i | input | 1 | Controller ODT |
| ctl_reset_n_i | input | 1 | Controller memory reset_n |
| ctl_rddata_o | output | 512 | Read data forwarded to the controller |
| ctl_rddata_valid_o | output | 4 | Read valid forwarded to the controller |
| dfi_cs_n_o | output | 4 | DFI chip select per phase |
| dfi_ras_n_o | output | 4 | DFI row strobe per phase |
| dfi_cas_n_o | output | 4 | DFI column strobe per phase |
| dfi_we_n_o | output | 4 | DFI write enable per phase |
| dfi_addr_o | output | 56 | DFI address per phase |
| dfi_bank_o | output | 12 | DFI bank per phase |
| dfi_wrdata_en_o | output | 4 | DFI write-data enable per phase |
| dfi_wrdata_o | output | 512 | DFI write data per phase |
| dfi_rddata_en_o | output | 4 | DFI read-data enable per phase |
| dfi_cke_o | output | 1 | DFI CKE |
| dfi_odt_o | output | 1 | DFI ODT |
| dfi_reset_n_o | output | 1 | DFI memory reset_n |
| dfi_rddata_i | input | 512 | Read data from the PHY |
| dfi_rddata_valid_i | input | 4 | Read valid from the PHY per phase |

## Verification
The assertions check four properties on every clock:
- Under software ownership, a phase drives NOP in every cycle that does not follow an issue write.
- A launch puts the staged chip-select and write-enable bits on the pins.
- Arming follows any launched read command.
- The captured read data moves only on an armed, valid cycle, and the control register takes each written value.

The bench scenarios are needed for the rest:
- the polarity of every command pin across a set of real command encodings;
- that a launch affects only its own phase;
- the address map, the write-data word order and the register readback;
- full pass-through of the controller's values;
- that an armed phase captures once and then ignores later read-valids.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;
  localparam int BUS_W = 32;
  localparam int REG_AW = 8;

  // offsets inside a phase region
  localparam logic [3:0] OFF_CMD   = 4'd0;
  localparam logic [3:0] OFF_ISSUE = 4'd1;
  localparam logic [3:0] OFF_ADDR  = 4'd2;
  localparam logic [3:0] OFF_BANK  = 4'd3;
  localparam logic [3:0] OFF_WR    = 4'd4;
  localparam logic [3:0] OFF_RD    = 4'd8;

  // command bits, active high
  localparam int CMD_CS   = 0;
  localparam int CMD_WE   = 1;
  localparam int CMD_CAS  = 2;
  localparam int CMD_RAS  = 3;
  localparam int CMD_WREN = 4;
  localparam int CMD_RDEN = 5;
  localparam int CMD_W    = 6;

  // control bits
  localparam int CT_SEL  = 0;
  localparam int CT_CKE  = 1;
  localparam int CT_ODT  = 2;
  localparam int CT_RSTN = 3;
  localparam int CT_W    = 4;
endpackage

// File: rtl/dfi_inj_ctrl.sv
module dfi_inj_ctrl
  import dfi_inj_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CT_W-1:0] wdata_i,
  output logic [CT_W-1:0] ctrl_o,
  output logic            sel_o,
  input  logic            ctl_cke_i,
  input  logic            ctl_odt_i,
  input  logic            ctl_reset_n_i,
  output logic            dfi_cke_o,
  output logic            dfi_odt_o,
  output logic            dfi_reset_n_o
);
  logic [CT_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o        = ctrl_q;
  assign sel_o         = ctrl_q[CT_SEL];
  assign dfi_cke_o     = sel_o ? ctrl_q[CT_CKE]  : ctl_cke_i;
  assign dfi_odt_o     = sel_o ? ctrl_q[CT_ODT]  : ctl_odt_i;
  assign dfi_reset_n_o = sel_o ? ctrl_q[CT_RSTN] : ctl_reset_n_i;

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/dfi_inj_phase.sv
module dfi_inj_phase
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [3:0]        off_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdback_o,
  input  logic              ctl_cs_n_i,
  input  logic              ctl_ras_n_i,
  input  logic              ctl_cas_n_i,
  input  logic              ctl_we_n_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic [BANK_W-1:0] ctl_bank_i,
  input  logic              ctl_wrdata_en_i,
  input  logic [DATA_W-1:0] ctl_wrdata_i,
  input  logic              ctl_rddata_en_i,
  output logic              ctl_rddata_valid_o,
  output logic              dfi_cs_n_o,
  output logic              dfi_ras_n_o,
  output logic              dfi_cas_n_o,
  output logic              dfi_we_n_o,
  output logic [ADDR_W-1:0] dfi_addr_o,
  output logic [BANK_W-1:0] dfi_bank_o,
  output logic              dfi_wrdata_en_o,
  output logic [DATA_W-1:0] dfi_wrdata_o,
  output logic              dfi_rddata_en_o,
  input  logic [DATA_W-1:0] dfi_rddata_i,
  input  logic              dfi_rddata_valid_i
);
  localparam int NW = DATA_W / BUS_W;

  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wr_q, rd_q;
  logic              issue_q, armed_q, launch_wr, fire;

  assign launch_wr = we_i && (off_i == OFF_ISSUE) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      bank_q  <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      issue_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      issue_q <= launch_wr;
      if (we_i) begin
        case (off_i)
          OFF_CMD:  cmd_q  <= wdata_i[CMD_W-1:0];
          OFF_ADDR: addr_q <= wdata_i[ADDR_W-1:0];
          OFF_BANK: bank_q <= wdata_i[BANK_W-1:0];
          default: begin
            for (int w = 0; w < NW; w++)
              if (off_i == OFF_WR + 4'(w)) wr_q[w*BUS_W +: BUS_W] <= wdata_i;
          end
        endcase
      end
      if (sel_i && armed_q && dfi_rddata_valid_i) begin
        rd_q    <= dfi_rddata_i;
        armed_q <= 1'b0;
      end
      // a new launch re-arms from its own read bit
      if (launch_wr) armed_q <= cmd_q[CMD_RDEN];
    end
  end

  always_comb begin
    rdback_o = '0;
    case (off_i)
      OFF_CMD:  rdback_o[CMD_W-1:0]  = cmd_q;
      OFF_ADDR: rdback_o[ADDR_W-1:0] = addr_q;
      OFF_BANK: rdback_o[BANK_W-1:0] = bank_q;
      default: begin
        for (int w = 0; w < NW; w++) begin
          if (off_i == OFF_WR + 4'(w)) rdback_o = wr_q[w*BUS_W +: BUS_W];
          if (off_i == OFF_RD + 4'(w)) rdback_o = rd_q[w*BUS_W +: BUS_W];
        end
      end
    endcase
  end

  assign fire = issue_q;

  // active-high staged bits become active-low pins here
  assign dfi_cs_n_o      = sel_i ? ~(fire & cmd_q[CMD_CS])  : ctl_cs_n_i;
  assign dfi_we_n_o      = sel_i ? ~(fire & cmd_q[CMD_WE])  : ctl_we_n_i;
  assign dfi_cas_n_o     = sel_i ? ~(fire & cmd_q[CMD_CAS]) : ctl_cas_n_i;
  assign dfi_ras_n_o     = sel_i ? ~(fire & cmd_q[CMD_RAS]) : ctl_ras_n_i;
  assign dfi_wrdata_en_o = sel_i ? (fire & cmd_q[CMD_WREN]) : ctl_wrdata_en_i;
  assign dfi_rddata_en_o = sel_i ? (fire & cmd_q[CMD_RDEN]) : ctl_rddata_en_i;
  assign dfi_addr_o      = sel_i ? addr_q : ctl_addr_i;
  assign dfi_bank_o      = sel_i ? bank_q : ctl_bank_i;
  assign dfi_wrdata_o    = sel_i ? wr_q   : ctl_wrdata_i;

  assign ctl_rddata_valid_o = dfi_rddata_valid_i & ~sel_i;

  // R8
  nop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_wr |=> (!sel_i || (dfi_cs_n_o && dfi_ras_n_o && dfi_cas_n_o && dfi_we_n_o
                               && !dfi_wrdata_en_o && !dfi_rddata_en_o)));

  // R7
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_wr |=> (!sel_i || (dfi_cs_n_o == !cmd_q[CMD_CS] && dfi_we_n_o == !cmd_q[CMD_WE])));

  // R9
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_wr && cmd_q[CMD_RDEN]) |=> armed_q);

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && armed_q && dfi_rddata_valid_i) |=> $stable(rd_q));
endmodule

// File: rtl/dfi_sw_inject.sv
module dfi_sw_inject
  import dfi_inj_pkg::*;
#(
  parameter int NPHASE = 4,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [REG_AW-1:0]          reg_addr_i,
  input  logic [BUS_W-1:0]           reg_wdata_i,
  output logic [BUS_W-1:0]           reg_rdata_o,
  input  logic [NPHASE-1:0]          ctl_cs_n_i,
  input  logic [NPHASE-1:0]          ctl_ras_n_i,
  input  logic [NPHASE-1:0]          ctl_cas_n_i,
  input  logic [NPHASE-1:0]          ctl_we_n_i,
  input  logic [NPHASE*ADDR_W-1:0]   ctl_addr_i,
  input  logic [NPHASE*BANK_W-1:0]   ctl_bank_i,
  input  logic [NPHASE-1:0]          ctl_wrdata_en_i,
  input  logic [NPHASE*DATA_W-1:0]   ctl_wrdata_i,
  input  logic [NPHASE-1:0]          ctl_rddata_en_i,
  input  logic                       ctl_cke_i,
  input  logic                       ctl_odt_i,
  input  logic                       ctl_reset_n_i,
  output logic [NPHASE*DATA_W-1:0]   ctl_rddata_o,
  output logic [NPHASE-1:0]          ctl_rddata_valid_o,
  output logic [NPHASE-1:0]          dfi_cs_n_o,
  output logic [NPHASE-1:0]          dfi_ras_n_o,
  output logic [NPHASE-1:0]          dfi_cas_n_o,
  output logic [NPHASE-1:0]          dfi_we_n_o,
  output logic [NPHASE*ADDR_W-1:0]   dfi_addr_o,
  output logic [NPHASE*BANK_W-1:0]   dfi_bank_o,
  output logic [NPHASE-1:0]          dfi_wrdata_en_o,
  output logic [NPHASE*DATA_W-1:0]   dfi_wrdata_o,
  output logic [NPHASE-1:0]          dfi_rddata_en_o,
  output logic                       dfi_cke_o,
  output logic                       dfi_odt_o,
  output logic                       dfi_reset_n_o,
  input  logic [NPHASE*DATA_W-1:0]   dfi_rddata_i,
  input  logic [NPHASE-1:0]          dfi_rddata_valid_i
);
  localparam int RGN_W = REG_AW - 4;

  logic [RGN_W-1:0] region;
  logic [3:0]       off;
  logic [CT_W-1:0]  ctrl;
  logic             sel, ctrl_we;
  logic [BUS_W-1:0] rb [NPHASE];

  assign region  = reg_addr_i[REG_AW-1:4];
  assign off     = reg_addr_i[3:0];
  assign ctrl_we = reg_we_i && (reg_addr_i == '0);

  dfi_inj_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i          (ctrl_we),
    .wdata_i       (reg_wdata_i[CT_W-1:0]),
    .ctrl_o        (ctrl),
    .sel_o         (sel),
    .ctl_cke_i, .ctl_odt_i, .ctl_reset_n_i,
    .dfi_cke_o, .dfi_odt_o, .dfi_reset_n_o
  );

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    dfi_inj_phase #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_phase (
      .clk_i, .rst_ni,
      .sel_i              (sel),
      .we_i               (reg_we_i && (region == RGN_W'(p + 1))),
      .off_i              (off),
      .wdata_i            (reg_wdata_i),
      .rdback_o           (rb[p]),
      .ctl_cs_n_i         (ctl_cs_n_i[p]),
      .ctl_ras_n_i        (ctl_ras_n_i[p]),
      .ctl_cas_n_i        (ctl_cas_n_i[p]),
      .ctl_we_n_i         (ctl_we_n_i[p]),
      .ctl_addr_i         (ctl_addr_i[p*ADDR_W +: ADDR_W]),
      .ctl_bank_i         (ctl_bank_i[p*BANK_W +: BANK_W]),
      .ctl_wrdata_en_i    (ctl_wrdata_en_i[p]),
      .ctl_wrdata_i       (ctl_wrdata_i[p*DATA_W +: DATA_W]),
      .ctl_rddata_en_i    (ctl_rddata_en_i[p]),
      .ctl_rddata_valid_o (ctl_rddata_valid_o[p]),
      .dfi_cs_n_o         (dfi_cs_n_o[p]),
      .dfi_ras_n_o        (dfi_ras_n_o[p]),
      .dfi_cas_n_o        (dfi_cas_n_o[p]),
      .dfi_we_n_o         (dfi_we_n_o[p]),
      .dfi_addr_o         (dfi_addr_o[p*ADDR_W +: ADDR_W]),
      .dfi_bank_o         (dfi_bank_o[p*BANK_W +: BANK_W]),
      .dfi_wrdata_en_o    (dfi_wrdata_en_o[p]),
      .dfi_wrdata_o       (dfi_wrdata_o[p*DATA_W +: DATA_W]),
      .dfi_rddata_en_o    (dfi_rddata_en_o[p]),
      .dfi_rddata_i       (dfi_rddata_i[p*DATA_W +: DATA_W]),
      .dfi_rddata_valid_i (dfi_rddata_valid_i[p])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == '0) reg_rdata_o[CT_W-1:0] = ctrl;
    for (int p = 0; p < NPHASE; p++)
      if (region == RGN_W'(p + 1)) reg_rdata_o = rb[p];
  end

  assign ctl_rddata_o = dfi_rddata_i;
endmodule

// File: tb/dfi_sw_inject_tb.sv
module dfi_sw_inject_tb;
  localparam int NP = 4, AW = 14, BW = 3, DW = 128;

  logic clk = 0, rst_ni = 0;
  always #4 clk = ~clk;

  logic           reg_we = 0;
  logic [7:0]     reg_addr = 0;
  logic [31:0]    reg_wdata = 0, reg_rdata;
  logic [NP-1:0]  c_cs_n = 4'b1010, c_ras_n = 4'b0110, c_cas_n = 4'b0011, c_we_n = 4'b1001;
  logic [NP*AW-1:0] c_addr = 56'h00A5_5A3C_C3F0_0F;
  logic [NP*BW-1:0] c_bank = 12'o7351;
  logic [NP-1:0]  c_wren = 4'b0101, c_rden = 4'b1100;
  logic [NP*DW-1:0] c_wrdata = {16{32'hC0DE_0000}} ^ 512'h1234;
  logic           c_cke = 1, c_odt = 1, c_rstn = 1;
  logic [NP*DW-1:0] c_rddata_o, d_wrdata, d_rddata = '0;
  logic [NP-1:0]  c_rdv_o, d_cs_n, d_ras_n, d_cas_n, d_we_n, d_wren, d_rden, d_rdv = '0;
  logic [NP*AW-1:0] d_addr;
  logic [NP*BW-1:0] d_bank;
  logic           d_cke, d_odt, d_rstn;

  dfi_sw_inject u_dut (
    .clk_i(clk), .rst_ni,
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ctl_cs_n_i(c_cs_n), .ctl_ras_n_i(c_ras_n), .ctl_cas_n_i(c_cas_n), .ctl_we_n_i(c_we_n),
    .ctl_addr_i(c_addr), .ctl_bank_i(c_bank), .ctl_wrdata_en_i(c_wren), .ctl_wrdata_i(c_wrdata),
    .ctl_rddata_en_i(c_rden), .ctl_cke_i(c_cke), .ctl_odt_i(c_odt), .ctl_reset_n_i(c_rstn),
    .ctl_rddata_o(c_rddata_o), .ctl_rddata_valid_o(c_rdv_o),
    .dfi_cs_n_o(d_cs_n), .dfi_ras_n_o(d_ras_n), .dfi_cas_n_o(d_cas_n), .dfi_we_n_o(d_we_n),
    .dfi_addr_o(d_addr), .dfi_bank_o(d_bank), .dfi_wrdata_en_o(d_wren), .dfi_wrdata_o(d_wrdata),
    .dfi_rddata_en_o(d_rden), .dfi_cke_o(d_cke), .dfi_odt_o(d_odt), .dfi_reset_n_o(d_rstn),
    .dfi_rddata_i(d_rddata), .dfi_rddata_valid_i(d_rdv)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [5:0] pins(input int p);
    return {d_cs_n[p], d_we_n[p], d_cas_n[p], d_ras_n[p], d_wren[p], d_rden[p]};
  endfunction

  // {phase, cmd, expected {cs_n,we_n,cas_n,ras_n,wren,rden}}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 6'h0F, 6'b000000},
    {2'd0, 6'h03, 6'b001100},
    {2'd2, 6'h15, 6'b010110},
    {2'd1, 6'h25, 6'b010101},
    {2'd3, 6'h09, 6'b011000},
    {2'd0, 6'h00, 6'b111100}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    chk("R1 cs_n pass", d_cs_n, c_cs_n);
    chk("R1 cke pass", {d_cke, d_odt, d_rstn}, 3'b111);
    rd(8'h10, v); chk("R1 cmd reg", v, 0);
    // R3 pass-through
    chk("R3 addr", d_addr, c_addr);
    chk("R3 bank", d_bank, c_bank);
    chk("R3 wrdata", d_wrdata, c_wrdata);
    chk("R3 strobes", {d_ras_n, d_cas_n, d_we_n, d_wren, d_rden}, {c_ras_n, c_cas_n, c_we_n, c_wren, c_rden});
    d_rdv = 4'b0011; #1;
    chk("R3 rdvalid fwd", c_rdv_o, 4'b0011);
    // R2 / R4 control
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R2 ctrl rb", v, 32'h1);
    chk("R4 pins low", {d_cke, d_odt, d_rstn}, 3'b000);
    // R10
    chk("R10 valid gated", c_rdv_o, 4'b0000);
    d_rddata = {16{32'h5A5A_0001}}; #1;
    chk("R10 data fwd", c_rddata_o, d_rddata);
    d_rdv = 0;
    wr(8'h00, 32'hB);
    rd(8'h00, v); chk("R2 ctrl 0xB", v, 32'hB);
    chk("R4 cke odt rstn", {d_cke, d_odt, d_rstn}, 3'b101);
    // R8 idle NOP
    chk("R8 idle nop", {d_cs_n, d_ras_n, d_cas_n, d_we_n, d_wren, d_rden}, {16'hFFFF, 8'h00});
    // R5 phase 2 registers
    wr(8'h32, 32'h1ABC);
    wr(8'h33, 32'h5);
    for (int w = 0; w < 4; w++) wr(8'h34 + 8'(w), 32'hA000_0000 + 32'(w));
    rd(8'h32, v); chk("R5 addr rb", v, 32'h1ABC);
    rd(8'h33, v); chk("R5 bank rb", v, 32'h5);
    rd(8'h36, v); chk("R5 wr word2 rb", v, 32'hA000_0002);
    rd(8'h31, v); chk("R5 issue reads 0", v, 0);
    chk("R4 addr out", d_addr[2*AW +: AW], 14'h1ABC);
    chk("R4 bank out", d_bank[2*BW +: BW], 3'd5);
    chk("R4 wrdata out", d_wrdata[2*DW +: DW], {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});
    // R6 / R7 / R8 vector walk
    foreach (VEC[i]) begin
      int p;
      p = int'(VEC[i][13:12]);
      wr(8'((p + 1) * 16), 32'(VEC[i][11:6]));
      wr(8'((p + 1) * 16 + 1), 32'h1);
      chk("R6 launch pins", pins(p), VEC[i][5:0]);
      chk("R7 other phases idle", d_cs_n | (4'b1 << p), 4'hF);
      @(negedge clk); #1;
      chk("R7 one cycle only", pins(p), 6'b111100);
    end
    // R7 issue with bit0 clear
    wr(8'h10, 32'h0F);
    wr(8'h11, 32'h2);
    chk("R7 no launch", {d_cs_n, d_ras_n}, 8'hFF);
    // R9 capture: phase 1 armed, phase 3 not
    d_rddata = {32'h3333_0003, 96'h0, 32'h2222_0002, 96'h0, 32'h1111_0001, 96'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    d_rddata[1*DW +: 32] = 32'hBEEF_0001;
    d_rddata[3*DW +: 32] = 32'hBEEF_0003;
    @(negedge clk); d_rdv = 4'b1010;
    @(negedge clk); d_rdv = 0;
    #1;
    rd(8'h28, v); chk("R9 armed capture", v, 32'hBEEF_0001);
    rd(8'h48, v); chk("R9 unarmed ignored", v, 0);
    d_rddata[1*DW +: 32] = 32'hDEAD_0001;
    @(negedge clk); d_rdv = 4'b0010;
    @(negedge clk); d_rdv = 0;
    #1;
    rd(8'h28, v); chk("R9 disarmed after capture", v, 32'hBEEF_0001);
    // R3 hand back
    wr(8'h00, 32'h0);
    chk("R3 back to ctl", {d_cs_n, d_addr}, {c_cs_n, c_addr});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule